// File: doc/BRIEF.md
# Dual-Clock FIFO Status Flag Generator

This block produces the five status flags of a dual-clock FIFO: empty, almost-empty, half-full, almost-full and full. All five are active low. It takes binary write and read pointers that have already been brought into each clock domain. It also takes two programmable thresholds: a low-water offset for almost-empty and a high-water offset for almost-full. The storage, the threshold programming path and the pointer synchronizers sit outside the block.

Two choices are made while reset is held, and both are frozen once reset is released. The first choice sets the timing of the two partial flags. In single-domain timing, each partial flag is owned by one clock. In mixed-clock timing, each partial flag is asserted by one clock and released by the other. The second choice sets how many register stages, from one to three, carry the empty and full flags to their outputs. Extra stages give more settling time at the empty and full boundaries, and each stage adds one clock of latency.

Top module: `pflag_gen`

## Requirements
- R1: While `rstN` is low, `emptyN` and `almostEmptyN` are 0, and `halfFullN`, `almostFullN` and `fullN` are 1.
- R2: Read-side occupancy is (`wrPtrR` − `rdPtr`) mod 2^(AW+1), with both pointers in binary. With one buffer stage, `emptyN` after each `rdClk` edge is 0 exactly when the occupancy sampled at that edge is 0.
- R3: Write-side occupancy is (`wrPtr` − `rdPtrW`) mod 2^(AW+1). With one buffer stage, `fullN` after each `wrClk` edge is 0 exactly when the occupancy sampled at that edge equals DEPTH.
- R4: After each `wrClk` edge, `halfFullN` is 0 exactly when the write-side occupancy sampled at that edge is greater than DEPTH/2.
- R5: In single-domain timing (`cfgAsync` = 0 at reset), `almostEmptyN` changes only on `rdClk` edges. After each such edge it is 0 exactly when the read-side occupancy is at most `emptyOffset`.
- R6: In single-domain timing, `almostFullN` changes only on `wrClk` edges. After each such edge it is 0 exactly when the write-side occupancy is at least DEPTH − `fullOffset`.
- R7: In mixed-clock timing (`cfgAsync` = 1 at reset), `almostEmptyN` goes to 0 on a `rdClk` edge whose read-side occupancy is at most `emptyOffset`. It returns to 1 on a `wrClk` edge whose write-side occupancy exceeds `emptyOffset`. No other event changes it.
- R8: In mixed-clock timing, `almostFullN` goes to 0 on a `wrClk` edge whose write-side occupancy is at least DEPTH − `fullOffset`. It returns to 1 on a `rdClk` edge whose read-side occupancy is below that threshold. No other event changes it.
- R9: `cfgStages` sampled during reset sets the buffer depth of the empty and full flags. A value of 0 or 1 gives one stage, 2 gives two and 3 gives three. Each stage beyond the first delays both assertion and release of that flag by one clock of its own domain.
- R10: `cfgAsync` and `cfgStages` take effect only on clock edges while `rstN` is low. Changing them after reset has no effect on any flag.
- R11: The buffer depth set by `cfgStages` has no effect on `almostEmptyN`, `almostFullN` or `halfFullN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock |
| rstN | input | 1 | Active-low reset, asynchronous assertion; the configuration is sampled while it is low |
| cfgAsync | input | 1 | 1 selects mixed-clock timing for the partial flags, 0 selects single-domain timing |
| cfgStages | input | 2 | Number of buffer stages for the empty and full flags (0 is treated as 1) |
| emptyOffset | input | AW | Almost-empty threshold, in words |
| fullOffset | input | AW | Almost-full threshold, counted back from DEPTH |
| wrPtr | input | AW+1 | Write pointer in the write domain |
| rdPtrW | input | AW+1 | Read pointer synchronized to the write domain |
| rdPtr | input | AW+1 | Read pointer in the read domain |
| wrPtrR | input | AW+1 | Write pointer synchronized to the read domain |
| emptyN | output | 1 | Empty flag, active low |
| almostEmptyN | output | 1 | Almost-empty flag, active low |
| halfFullN | output | 1 | Half-full flag, active low |
| almostFullN | output | 1 | Almost-full flag, active low |
| fullN | output | 1 | Full flag, active low |

## Verification
The bench exercises the following corner cases:

- **Exact occupancy boundaries.** It drives occupancy across zero, the low-water mark, the midpoint, the high-water mark and DEPTH. It uses offsets of zero and nonzero values, so a comparator with the wrong sense (< instead of <=, or a threshold off by one) shows up as a flag that is one word early or late.
- **Mixed-clock timing.** It checks which clock may assert each partial flag and which may release it. A design that lets the wrong domain act would move the flag at an edge of the other clock.
- **Buffer depths.** It runs all four `cfgStages` codes. A chain tapped at the wrong place would delay empty or full by the wrong number of edges. A chain placed on a partial flag would make that flag lag.
- **Configuration after reset.** It flips both configuration inputs after reset is released. A design that keeps sampling them would change behaviour part way through a run.

// File: rtl/pflag_pkg.sv
`timescale 1ns/100ps
package pflag_pkg;
  localparam int MAX_TAPS = 3;
  localparam int STG_W    = $clog2(MAX_TAPS + 1);

  // Strobes handed from a domain's control to the datapath.
  typedef struct packed {
    logic                asyncMode;
    logic [MAX_TAPS-1:0] tapSel;
  } flagCfg_t;
endpackage

// File: rtl/pflag_ctrl.sv
`timescale 1ns/100ps
module pflag_ctrl
  import pflag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgAsync,
  input  logic [STG_W-1:0] cfgStages,
  output flagCfg_t         cfg
);
  logic [STG_W-1:0]    stagesEff;
  logic [MAX_TAPS-1:0] tapDecoded;
  flagCfg_t            held;

  assign stagesEff = (cfgStages == '0) ? STG_W'(1) : cfgStages;

  always_comb begin
    for (int i = 0; i < MAX_TAPS; i++) begin
      tapDecoded[i] = (int'(stagesEff) == i + 1);
    end
  end

  // Configuration is sampled on every edge while reset is held, then frozen.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      held.asyncMode <= cfgAsync;
      held.tapSel    <= tapDecoded;
    end
  end

  assign cfg = held;
endmodule

// File: rtl/pflag_stage_chain.sv
`timescale 1ns/100ps
module pflag_stage_chain #(
  parameter int TAPS    = 3,
  parameter bit RST_VAL = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            d,
  input  logic [TAPS-1:0] tapSel,
  output logic            q
);
  logic stg [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : gStage
    if (i == 0) begin : gHead
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[i] <= RST_VAL;
        else       stg[i] <= d;
      end
    end else begin : gBody
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[i] <= RST_VAL;
        else       stg[i] <= stg[i-1];
      end
    end
  end

  always_comb begin
    q = 1'b0;
    for (int i = 0; i < TAPS; i++) begin
      q = q | (stg[i] & tapSel[i]);
    end
  end
endmodule

// File: rtl/pflag_datapath.sv
`timescale 1ns/100ps
module pflag_datapath
  import pflag_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  flagCfg_t      wrCfg,
  input  flagCfg_t      rdCfg,
  input  logic [AW-1:0] emptyOffset,
  input  logic [AW-1:0] fullOffset,
  input  logic [AW:0]   wrPtr,
  input  logic [AW:0]   rdPtrW,
  input  logic [AW:0]   rdPtr,
  input  logic [AW:0]   wrPtrR,
  output logic          emptyN,
  output logic          almostEmptyN,
  output logic          halfFullN,
  output logic          almostFullN,
  output logic          fullN
);
  localparam int            CW       = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [CW-1:0] occW, occR, afThresh, aeThresh;
  logic rdZero, wrTop, wrHalf;
  logic rdAeHit, wrAeClear, wrAfHit, rdAfClear;

  assign occW     = wrPtr - rdPtrW;
  assign occR     = wrPtrR - rdPtr;
  assign aeThresh = {1'b0, emptyOffset};
  assign afThresh = FULL_CNT - {1'b0, fullOffset};

  assign rdZero    = (occR == '0);
  assign wrTop     = (occW == FULL_CNT);
  assign wrHalf    = (occW > HALF_CNT);
  assign rdAeHit   = (occR <= aeThresh);
  assign wrAeClear = (occW > aeThresh);
  assign wrAfHit   = (occW >= afThresh);
  assign rdAfClear = (occR < afThresh);

  // Boundary flags through selectable-depth chains.
  logic emptyHit, fullHit;

  pflag_stage_chain #(.TAPS(MAX_TAPS), .RST_VAL(1'b1)) uEmptyChain (
    .clk(rdClk), .rstN(rstN), .d(rdZero), .tapSel(rdCfg.tapSel), .q(emptyHit)
  );

  pflag_stage_chain #(.TAPS(MAX_TAPS), .RST_VAL(1'b0)) uFullChain (
    .clk(wrClk), .rstN(rstN), .d(wrTop), .tapSel(wrCfg.tapSel), .q(fullHit)
  );

  // Half-full, write domain.
  logic halfHit;
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) halfHit <= 1'b0;
    else       halfHit <= wrHalf;
  end

  // Single-domain partial flags.
  logic aeLowSync, afLowSync;
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) aeLowSync <= 1'b1;
    else       aeLowSync <= rdAeHit;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) afLowSync <= 1'b0;
    else       afLowSync <= wrAfHit;
  end

  // Mixed-clock partial flags: one toggle per domain, state is their XOR.
  logic aeTogR, aeTogW, afTogR, afTogW;
  logic aeLowMixed, afLowMixed;

  assign aeLowMixed = aeTogR ^ aeTogW;
  assign afLowMixed = afTogR ^ afTogW;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      aeTogR <= 1'b1;
      afTogR <= 1'b0;
    end else begin
      if (rdAeHit && !aeLowMixed)  aeTogR <= ~aeTogR;
      if (rdAfClear && afLowMixed) afTogR <= ~afTogR;
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeTogW <= 1'b0;
      afTogW <= 1'b0;
    end else begin
      if (wrAeClear && aeLowMixed) aeTogW <= ~aeTogW;
      if (wrAfHit && !afLowMixed)  afTogW <= ~afTogW;
    end
  end

  assign emptyN       = ~emptyHit;
  assign fullN        = ~fullHit;
  assign halfFullN    = ~halfHit;
  assign almostEmptyN = ~(rdCfg.asyncMode ? aeLowMixed : aeLowSync);
  assign almostFullN  = ~(wrCfg.asyncMode ? afLowMixed : afLowSync);
endmodule

// File: rtl/pflag_gen.sv
`timescale 1ns/100ps
module pflag_gen
  import pflag_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             cfgAsync,
  input  logic [STG_W-1:0] cfgStages,
  input  logic [AW-1:0]    emptyOffset,
  input  logic [AW-1:0]    fullOffset,
  input  logic [AW:0]      wrPtr,
  input  logic [AW:0]      rdPtrW,
  input  logic [AW:0]      rdPtr,
  input  logic [AW:0]      wrPtrR,
  output logic             emptyN,
  output logic             almostEmptyN,
  output logic             halfFullN,
  output logic             almostFullN,
  output logic             fullN
);
  flagCfg_t wrCfg, rdCfg;

  pflag_ctrl uWrCtrl (
    .clk(wrClk), .rstN(rstN), .cfgAsync(cfgAsync), .cfgStages(cfgStages), .cfg(wrCfg)
  );

  pflag_ctrl uRdCtrl (
    .clk(rdClk), .rstN(rstN), .cfgAsync(cfgAsync), .cfgStages(cfgStages), .cfg(rdCfg)
  );

  pflag_datapath #(.DEPTH(DEPTH), .AW(AW)) uPath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrCfg(wrCfg), .rdCfg(rdCfg),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset),
    .wrPtr(wrPtr), .rdPtrW(rdPtrW), .rdPtr(rdPtr), .wrPtrR(wrPtrR),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN), .halfFullN(halfFullN),
    .almostFullN(almostFullN), .fullN(fullN)
  );
endmodule

// File: rtl/pflag_gen_chk.sv
`timescale 1ns/100ps
module pflag_gen_chk #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          rstN,
  input logic          asyncR,
  input logic          asyncW,
  input logic [AW-1:0] emptyOffset,
  input logic [AW-1:0] fullOffset,
  input logic [AW:0]   wrPtr,
  input logic [AW:0]   rdPtrW,
  input logic [AW:0]   rdPtr,
  input logic [AW:0]   wrPtrR,
  input logic          emptyN,
  input logic          almostEmptyN,
  input logic          halfFullN,
  input logic          almostFullN,
  input logic          fullN
);
  localparam int            CW   = AW + 1;
  localparam logic [CW-1:0] TOP  = CW'(DEPTH);
  localparam logic [CW-1:0] MID  = CW'(DEPTH / 2);

  logic [CW-1:0] wOcc, rOcc, hiMark, loMark;
  assign wOcc   = wrPtr - rdPtrW;
  assign rOcc   = wrPtrR - rdPtr;
  assign loMark = {1'b0, emptyOffset};
  assign hiMark = TOP - {1'b0, fullOffset};

  assert_empty_full_exclusive_R2: assert property (@(posedge wrClk) disable iff (!rstN)
    !(!emptyN && !fullN));

  assert_half_set_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    (wOcc > MID) |=> !halfFullN);

  assert_half_clear_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    (wOcc <= MID) |=> halfFullN);

  assert_ae_sync_set_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    (!asyncR && rOcc <= loMark) |=> !almostEmptyN);

  assert_ae_sync_clear_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    (!asyncR && rOcc > loMark) |=> almostEmptyN);

  assert_af_sync_set_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    (!asyncW && wOcc >= hiMark) |=> !almostFullN);

  assert_af_sync_clear_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    (!asyncW && wOcc < hiMark) |=> almostFullN);
endmodule

bind pflag_gen pflag_gen_chk #(.DEPTH(DEPTH), .AW(AW)) uChk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .asyncR(rdCfg.asyncMode), .asyncW(wrCfg.asyncMode),
  .emptyOffset(emptyOffset), .fullOffset(fullOffset),
  .wrPtr(wrPtr), .rdPtrW(rdPtrW), .rdPtr(rdPtr), .wrPtrR(wrPtrR),
  .emptyN(emptyN), .almostEmptyN(almostEmptyN), .halfFullN(halfFullN),
  .almostFullN(almostFullN), .fullN(fullN)
);

// File: tb/tb_pflag_gen.sv
`timescale 1ns/100ps
module tb_pflag_gen;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic          wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic          cfgAsync = 1'b0;
  logic [1:0]    cfgStages = 2'd1;
  logic [AW-1:0] emptyOffset = '0, fullOffset = '0;
  logic [AW:0]   wrPtr = '0, rdPtr = '0;
  logic [AW:0]   rdPtrW, wrPtrR;
  logic          emptyN, almostEmptyN, halfFullN, almostFullN, fullN;

  assign rdPtrW = rdPtr;
  assign wrPtrR = wrPtr;

  pflag_gen #(.DEPTH(DEPTH)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .cfgAsync(cfgAsync), .cfgStages(cfgStages),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset),
    .wrPtr(wrPtr), .rdPtrW(rdPtrW), .rdPtr(rdPtr), .wrPtrR(wrPtrR),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN), .halfFullN(halfFullN),
    .almostFullN(almostFullN), .fullN(fullN)
  );

  // 200 MHz write clock (rising at x.5 ns); read clock 125 MHz rising at integer ns.
  always #2.5 wrClk = ~wrClk;
  initial begin
    #1 rdClk = 1'b1;
    forever #4 rdClk = ~rdClk;
  end

  int checks = 0, fails = 0;
  bit checking = 0, done = 0;
  int wrRate = 0, rdRate = 0;

  // Reference model state
  bit expEmpty = 1, expAeLow = 1, expHfLow = 0, expAfLow = 0, expFull = 0;
  bit eHist [3];
  bit fHist [3];
  bit mAsyncR = 0, mAsyncW = 0;
  int mStR = 1, mStW = 1;

  function automatic int occ();
    logic [AW:0] d;
    d = wrPtr - rdPtr;
    return int'(d);
  endfunction

  always @(posedge rdClk) begin : modelRd
    int c;
    c = occ();
    if (!rstN) begin
      mAsyncR  = cfgAsync;
      mStR     = (cfgStages == 0) ? 1 : int'(cfgStages);
      expAeLow = 1;
      expAfLow = 0;
      for (int i = 0; i < 3; i++) eHist[i] = 1;
    end else begin
      eHist[2] = eHist[1];
      eHist[1] = eHist[0];
      eHist[0] = (c == 0);
      if (mAsyncR) begin
        if (c <= int'(emptyOffset)) expAeLow = 1;
        if (c < DEPTH - int'(fullOffset)) expAfLow = 0;
      end else begin
        expAeLow = (c <= int'(emptyOffset));
      end
    end
    expEmpty = eHist[mStR-1];
  end

  always @(posedge wrClk) begin : modelWr
    int c;
    c = occ();
    if (!rstN) begin
      mAsyncW  = cfgAsync;
      mStW     = (cfgStages == 0) ? 1 : int'(cfgStages);
      expAfLow = 0;
      expHfLow = 0;
      expAeLow = 1;
      for (int i = 0; i < 3; i++) fHist[i] = 0;
    end else begin
      fHist[2] = fHist[1];
      fHist[1] = fHist[0];
      fHist[0] = (c == DEPTH);
      expHfLow = (c > DEPTH / 2);
      if (mAsyncW) begin
        if (c >= DEPTH - int'(fullOffset)) expAfLow = 1;
        if (c > int'(emptyOffset)) expAeLow = 0;
      end else begin
        expAfLow = (c >= DEPTH - int'(fullOffset));
      end
    end
    expFull = fHist[mStW-1];
  end

  task automatic check(input logic got, input logic exp, input string req, input string name);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %b expected %b (occupancy %0d)",
               req, name, $time, got, exp, occ());
    end
  endtask

  task automatic compareAll();
    check(emptyN, ~expEmpty, (mStR > 1) ? "R2 R9 R10" : "R2 R10", "emptyN");
    check(fullN, ~expFull, (mStW > 1) ? "R3 R9 R10" : "R3 R10", "fullN");
    check(halfFullN, ~expHfLow, "R4 R11", "halfFullN");
    check(almostEmptyN, ~expAeLow, mAsyncR ? "R7 R10 R11" : "R5 R10 R11", "almostEmptyN");
    check(almostFullN, ~expAfLow, mAsyncW ? "R8 R10 R11" : "R6 R10 R11", "almostFullN");
  endtask

  always begin
    @(posedge rdClk); #1;
    if (checking) compareAll();
  end

  always begin
    @(posedge wrClk); #1;
    if (checking) compareAll();
  end

  // Traffic generators: pointers move away from both clocks' edges.
  always begin
    @(posedge wrClk); #2;
    if (rstN && $urandom_range(99) < wrRate && occ() != DEPTH) wrPtr = wrPtr + 1'b1;
  end

  always begin
    @(posedge rdClk); #3;
    if (rstN && $urandom_range(99) < rdRate && occ() != 0) rdPtr = rdPtr + 1'b1;
  end

  task automatic traffic(input int w, input int r, input int cycles);
    wrRate = w;
    rdRate = r;
    repeat (cycles) @(posedge wrClk);
  endtask

  task automatic runPhase(input bit am, input logic [1:0] st, input int n, input int m);
    @(posedge rdClk); #2;
    checking = 0;
    rstN     = 0;
    wrRate   = 0;
    rdRate   = 0;
    wrPtr    = '0;
    rdPtr    = '0;
    cfgAsync = am;
    cfgStages = st;
    emptyOffset = AW'(n);
    fullOffset  = AW'(m);
    repeat (4) @(posedge rdClk);
    #2;
    check(emptyN, 1'b0, "R1", "emptyN");
    check(almostEmptyN, 1'b0, "R1", "almostEmptyN");
    check(halfFullN, 1'b1, "R1", "halfFullN");
    check(almostFullN, 1'b1, "R1", "almostFullN");
    check(fullN, 1'b1, "R1", "fullN");
    rstN = 1;
    // R10: configuration inputs move after reset and must be ignored.
    cfgAsync  = ~am;
    cfgStages = st + 2'd1;
    checking  = 1;
    traffic(80, 15, 250);
    traffic(15, 85, 300);
    traffic(100, 0, 120);
    traffic(0, 100, 120);
    traffic(50, 50, 200);
    traffic(70, 60, 150);
    traffic(100, 30, 100);
    traffic(0, 100, 100);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    runPhase(1'b0, 2'd1, 5, 6);
    runPhase(1'b0, 2'd2, 0, 1);
    runPhase(1'b0, 2'd3, 7, 3);
    runPhase(1'b0, 2'd0, 4, 0);
    runPhase(1'b1, 2'd1, 5, 6);
    runPhase(1'b1, 2'd2, 3, 4);
    runPhase(1'b1, 2'd3, 6, 2);
    runPhase(1'b1, 2'd0, 0, 0);
    @(posedge rdClk); #2;
    checking = 0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      summary();
      $finish;
    end
  end
endmodule